// File: doc/BRIEF.md
# Signalling Unit Repeat-Fill Filter

This block sits on the receive side of a signalling link, between the deframer that has already removed flags, bit stuffing and the checksum, and the receive FIFO. Received units arrive as a byte stream marked with start, end and abort strobes. Each unit is held in a small ring until its end strobe is seen. The block then decides whether to forward the unit to the FIFO or to drop it. Because of this, a dropped unit never leaves stray bytes downstream.

A unit counts as a fill-in unit when it is at least three octets long and the low six bits of its third octet (the length indicator) are zero. When filtering is enabled, a fill-in unit whose backward sequence number matches that of the previous fill-in unit is discarded silently. The backward sequence number is the low seven bits of the first octet. Every other unit passes unchanged.

A rising edge on the flush control empties the block and forgets the stored sequence number. The source-select input has no effect on filtering; it is only echoed on a status output.

Top module: `su_dup_filter`

## Requirements
- R1: After reset, `out_valid` is low, nothing is pending, and no reference sequence number is held, so the first fill-in unit passes.
- R2: With `filt_en` low, every unit is forwarded, including fill-in units that repeat the previous sequence number.
- R3: With `filt_en` high, a fill-in unit is dropped whole when its sequence number (first octet bits 6:0) equals the stored reference. First-octet bit 7 and third-octet bits 7:6 take no part in the decision.
- R4: A forwarded fill-in unit with a new sequence number becomes the reference. A dropped repeat keeps the reference valid, so every unit in a run of identical fill-in units after the first is dropped.
- R5: A unit that is not a fill-in unit is forwarded unchanged and invalidates the reference. This covers a length indicator other than zero and a unit of one or two octets.
- R6: `in_abort` discards the partial unit, produces no output and invalidates the reference.
- R7: A start strobe inside an open unit discards the partial unit, invalidates the reference and begins a new unit. Bytes presented with no unit open are ignored.
- R8: A unit longer than `MAX_LEN` octets is discarded whole and invalidates the reference. A unit of exactly `MAX_LEN` octets is forwarded.
- R9: Forwarded units appear on the output byte for byte, in arrival order and never interleaved. `out_first` marks the first byte and `out_last` marks the last byte.
- R10: The reference is updated by fill-in units even while `filt_en` is low.
- R11: A rising edge of `flush_ctl` drops all pending output bytes within one cycle and invalidates the reference. Holding `flush_ctl` high has no further effect.
- R12: `map_sel_st` equals `map_sel` delayed by one clock, and `map_sel` does not alter filtering.
- R13: With units arriving back to back at one byte per cycle, no byte is lost to ring overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte opens a unit |
| in_last | input | 1 | Byte closes a unit |
| in_abort | input | 1 | Abandon the open unit |
| filt_en | input | 1 | Enable repeat filtering |
| flush_ctl | input | 1 | Flush control, acts on rising edge |
| map_sel | input | 1 | Receive source select (status only) |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First byte of a forwarded unit |
| out_last | output | 1 | Last byte of a forwarded unit |
| map_sel_st | output | 1 | Registered copy of map_sel |

## Verification
Some properties are checked by assertions on every cycle:
- The ring never overflows.
- Every forwarded unit opens with a first-marked byte, and no first mark appears inside a unit.
- A drop or abort leaves the commit pointer untouched.
- The output goes quiet in the cycle after a flush edge.

Other behaviour is shown only by the bench scenarios, whose scoreboard compares whole byte streams. These cover the decision itself, when the reference becomes valid or invalid, the role of the ignored indicator and spare bits, the overlong-unit limit, stray bytes, held flush, and tracking while filtering is disabled.

// File: rtl/su_filter_pkg.sv
package su_filter_pkg;

    localparam int BYTE_W = 8;
    localparam int SEQ_W  = 7;

    typedef struct packed {
        logic              first;
        logic              last;
        logic [BYTE_W-1:0] data;
    } su_byte_t;

    typedef struct packed {
        logic push;        // write the entry into the ring
        logic begin_unit;  // entry opens a unit: remember its slot
        logic rewind;      // discard the open unit before this cycle's push
        logic commit;      // make everything written so far visible to output
    } ring_op_t;

    function automatic logic [SEQ_W-1:0] seq_of(input logic [BYTE_W-1:0] octet);
        return octet[SEQ_W-1:0];
    endfunction

    function automatic logic len_is_zero(input logic [BYTE_W-1:0] octet);
        return octet[5:0] == 6'd0;
    endfunction

endpackage

// File: rtl/su_flush_edge.sv
module su_flush_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign pulse = lvl & ~lvl_q;
endmodule

// File: rtl/su_intake.sv
module su_intake
    import su_filter_pkg::*;
#(
    parameter int MAX_LEN = 72
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_abort,
    input  logic              filt_en,
    output ring_op_t          op_o,
    output su_byte_t          entry_o
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_LEN);

    logic             open_q,   open_n;
    logic [CNT_W-1:0] cnt_q,    cnt_n;
    logic [SEQ_W-1:0] seq_q,    seq_n;
    logic             lz_q,     lz_n;
    logic             ref_ok_q, ref_ok_n;
    logic [SEQ_W-1:0] ref_q,    ref_n;

    logic [CNT_W-1:0] cnt_eff;
    logic [SEQ_W-1:0] cur_seq;
    logic             cur_lz;
    logic             is_fill;
    logic             is_repeat;

    always_comb begin
        cnt_eff   = in_first ? '0 : cnt_q;
        cur_seq   = (cnt_eff == CNT_W'(0)) ? seq_of(in_data) : seq_q;
        cur_lz    = (cnt_eff == CNT_W'(2)) ? len_is_zero(in_data) : lz_q;
        is_fill   = (cnt_eff >= CNT_W'(2)) && cur_lz;
        is_repeat = is_fill && ref_ok_q && (ref_q == cur_seq);
    end

    always_comb begin
        open_n   = open_q;
        cnt_n    = cnt_q;
        seq_n    = seq_q;
        lz_n     = lz_q;
        ref_ok_n = ref_ok_q;
        ref_n    = ref_q;
        op_o     = '0;
        entry_o  = '{first: in_first, last: in_last, data: in_data};

        if (in_abort) begin
            op_o.rewind = open_q;
            open_n      = 1'b0;
            ref_ok_n    = 1'b0;
        end else if (in_valid && (in_first || open_q)) begin
            if (!in_first && cnt_q == CNT_LIMIT) begin
                // overlong unit: discard it and skip the remainder
                op_o.rewind = 1'b1;
                open_n      = 1'b0;
                ref_ok_n    = 1'b0;
            end else begin
                if (in_first && open_q) begin
                    op_o.rewind = 1'b1;
                    ref_ok_n    = 1'b0;
                end
                if (in_last) begin
                    open_n = 1'b0;
                    if (is_fill) begin
                        ref_ok_n = 1'b1;
                        ref_n    = cur_seq;
                    end else begin
                        ref_ok_n = 1'b0;
                    end
                    if (is_repeat && filt_en) begin
                        op_o.rewind = 1'b1;
                    end else begin
                        op_o.push       = 1'b1;
                        op_o.begin_unit = in_first;
                        op_o.commit     = 1'b1;
                    end
                end else begin
                    op_o.push       = 1'b1;
                    op_o.begin_unit = in_first;
                    open_n          = 1'b1;
                    cnt_n           = cnt_eff + CNT_W'(1);
                    seq_n           = cur_seq;
                    lz_n            = cur_lz;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            open_q   <= 1'b0;
            cnt_q    <= '0;
            seq_q    <= '0;
            lz_q     <= 1'b0;
            ref_ok_q <= 1'b0;
            ref_q    <= '0;
        end else begin
            open_q   <= open_n;
            cnt_q    <= cnt_n;
            seq_q    <= seq_n;
            lz_q     <= lz_n;
            ref_ok_q <= ref_ok_n;
            ref_q    <= ref_n;
        end
    end
endmodule

// File: rtl/su_ring.sv
module su_ring
    import su_filter_pkg::*;
#(
    parameter int MAX_LEN = 72
) (
    input  logic     clk,
    input  logic     clr,
    input  ring_op_t op_i,
    input  su_byte_t entry_i,
    output logic     out_valid_o,
    output su_byte_t out_entry_o
);
    localparam int DEPTH = 2 ** $clog2(2 * MAX_LEN + 2);
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 1;

    su_byte_t mem [DEPTH];

    logic [PW-1:0] wr_q, start_q, cm_q, rd_q;
    logic [PW-1:0] eff_wr, wr_n, start_n;
    logic          mid_q;

    always_comb begin
        eff_wr  = op_i.rewind ? start_q : wr_q;
        wr_n    = eff_wr + PW'(op_i.push);
        start_n = op_i.begin_unit ? eff_wr : start_q;
    end

    always_ff @(posedge clk) begin
        if (!clr && op_i.push) mem[eff_wr[AW-1:0]] <= entry_i;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_q        <= '0;
            start_q     <= '0;
            cm_q        <= '0;
            rd_q        <= '0;
            out_valid_o <= 1'b0;
            out_entry_o <= '0;
        end else begin
            wr_q    <= wr_n;
            start_q <= start_n;
            if (op_i.commit) cm_q <= wr_n;
            if (rd_q != cm_q) begin
                out_valid_o <= 1'b1;
                out_entry_o <= mem[rd_q[AW-1:0]];
                rd_q        <= rd_q + PW'(1);
            end else begin
                out_valid_o <= 1'b0;
            end
        end
    end

    // output framing tracker for the checks below
    always_ff @(posedge clk) begin
        if (clr)              mid_q <= 1'b0;
        else if (out_valid_o) mid_q <= !out_entry_o.last;
    end

    logic [PW-1:0] occupancy;
    assign occupancy = wr_q - rd_q;

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (clr)
        occupancy < PW'(DEPTH));

    assert_unit_starts_R9: assert property (@(posedge clk) disable iff (clr)
        (out_valid_o && !mid_q) |-> out_entry_o.first);

    assert_unit_continues_R9: assert property (@(posedge clk) disable iff (clr)
        (out_valid_o && mid_q) |-> !out_entry_o.first);

    assert_drop_keeps_commit_R3: assert property (@(posedge clk) disable iff (clr)
        (op_i.rewind && !op_i.push) |=> $stable(cm_q));
endmodule

// File: rtl/su_dup_filter.sv
module su_dup_filter
    import su_filter_pkg::*;
#(
    parameter int MAX_LEN = 72
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_first,
    input  logic       in_last,
    input  logic       in_abort,
    input  logic       filt_en,
    input  logic       flush_ctl,
    input  logic       map_sel,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    output logic       map_sel_st
);
    logic     flush_pulse;
    logic     clr;
    ring_op_t op;
    su_byte_t entry;
    su_byte_t out_entry;

    su_flush_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (flush_ctl),
        .pulse (flush_pulse)
    );

    assign clr = rst | flush_pulse;

    su_intake #(.MAX_LEN(MAX_LEN)) u_intake (
        .clk      (clk),
        .clr      (clr),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_first (in_first),
        .in_last  (in_last),
        .in_abort (in_abort),
        .filt_en  (filt_en),
        .op_o     (op),
        .entry_o  (entry)
    );

    su_ring #(.MAX_LEN(MAX_LEN)) u_ring (
        .clk         (clk),
        .clr         (clr),
        .op_i        (op),
        .entry_i     (entry),
        .out_valid_o (out_valid),
        .out_entry_o (out_entry)
    );

    assign out_data  = out_entry.data;
    assign out_first = out_entry.first;
    assign out_last  = out_entry.last;

    always_ff @(posedge clk) begin
        if (rst) map_sel_st <= 1'b0;
        else     map_sel_st <= map_sel;
    end

    assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |=> !out_valid);
endmodule

// File: tb/sim_su_dup_filter.sv
module sim_su_dup_filter;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT_MAX   = 72;
    localparam int Q          = CLK_PERIOD / 4;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_abort = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       filt_en = 1'b0, flush_ctl = 1'b0, map_sel = 1'b0;
    logic       out_valid, out_first, out_last, map_sel_st;
    logic [7:0] out_data;

    int checks = 0;
    int fails  = 0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    su_dup_filter #(.MAX_LEN(UNIT_MAX)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_first(in_first),
        .in_last(in_last), .in_abort(in_abort),
        .filt_en(filt_en), .flush_ctl(flush_ctl), .map_sel(map_sel),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .map_sel_st(map_sel_st)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected output byte", int'(out_data), -1);
            end else begin
                logic [9:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_first, out_last, out_data} == e, t, "output byte",
                      int'({out_first, out_last, out_data}), int'(e));
            end
        end
    end

    function automatic bq_t mk_fill(input logic [7:0] b0, input logic [7:0] li);
        bq_t q;
        q = {b0, 8'h2A, li};
        return q;
    endfunction

    function automatic bq_t mk_unit(input logic [7:0] b0, input logic [7:0] li, input int len);
        bq_t q;
        for (int i = 0; i < len; i++) begin
            if (i == 0)      q.push_back(b0);
            else if (i == 2) q.push_back(li);
            else             q.push_back(8'(i * 7 + 3));
        end
        return q;
    endfunction

    task automatic send_unit(input bq_t u, input bit pass, input string tag);
        if (pass) begin
            for (int i = 0; i < u.size(); i++) begin
                exp_q.push_back({(i == 0), (i == u.size() - 1), u[i]});
                tag_q.push_back(tag);
            end
        end
        for (int i = 0; i < u.size(); i++) begin
            @(posedge clk); #(Q);
            in_valid = 1'b1;
            in_data  = u[i];
            in_first = (i == 0);
            in_last  = (i == u.size() - 1);
        end
    endtask

    task automatic send_partial(input bq_t u, input bit with_first);
        for (int i = 0; i < u.size(); i++) begin
            @(posedge clk); #(Q);
            in_valid = 1'b1;
            in_data  = u[i];
            in_first = with_first && (i == 0);
            in_last  = 1'b0;
        end
    endtask

    task automatic stray_bytes(input bq_t u);
        for (int i = 0; i < u.size(); i++) begin
            @(posedge clk); #(Q);
            in_valid = 1'b1;
            in_data  = u[i];
            in_first = 1'b0;
            in_last  = (i == u.size() - 1);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #(Q);
            in_valid = 1'b0;
            in_first = 1'b0;
            in_last  = 1'b0;
            in_abort = 1'b0;
        end
    endtask

    task automatic abort_unit();
        @(posedge clk); #(Q);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
        in_abort = 1'b1;
        @(posedge clk); #(Q);
        in_abort = 1'b0;
    endtask

    task automatic settle(input string tag);
        idle(2 * UNIT_MAX + 30);
        check(exp_q.size() == 0, tag, "expected bytes still missing", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #(Q);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(map_sel_st == 1'b0, "R12", "status after reset", map_sel_st, 0);

        // R1: first fill-in unit passes, nothing stored yet
        filt_en = 1'b1;
        send_unit(mk_fill(8'h03, 8'h00), 1, "R1");
        // R3: repeat dropped; R4: run of repeats all dropped
        send_unit(mk_fill(8'h03, 8'h00), 0, "R3");
        send_unit(mk_fill(8'h03, 8'h00), 0, "R4");
        // R4: new sequence number passes and becomes the reference
        send_unit(mk_fill(8'h04, 8'h00), 1, "R4");
        // R3: indicator bit 7 ignored, spare length bits ignored
        send_unit(mk_fill(8'h84, 8'h00), 0, "R3");
        send_unit(mk_fill(8'h04, 8'hC0), 0, "R3");
        settle("R3");

        // R5: non-fill unit passes and clears the reference
        send_unit(mk_unit(8'h04, 8'h05, 8), 1, "R5");
        send_unit(mk_fill(8'h04, 8'h00), 1, "R5");
        send_unit(mk_unit(8'h04, 8'h00, 2), 1, "R5");
        send_unit(mk_fill(8'h04, 8'h00), 1, "R5");
        settle("R5");

        // R2: filtering disabled forwards repeats
        filt_en = 1'b0;
        send_unit(mk_fill(8'h04, 8'h00), 1, "R2");
        send_unit(mk_fill(8'h04, 8'h00), 1, "R2");
        // R10: reference tracked while disabled
        send_unit(mk_fill(8'h09, 8'h00), 1, "R10");
        idle(1);
        filt_en = 1'b1;
        send_unit(mk_fill(8'h09, 8'h00), 0, "R10");
        settle("R10");

        // R6: abort discards and clears reference
        send_partial(mk_unit(8'h09, 8'h01, 2), 1);
        abort_unit();
        send_unit(mk_fill(8'h09, 8'h00), 1, "R6");
        settle("R6");

        // R7: start inside an open unit restarts and clears reference
        send_partial(mk_unit(8'h09, 8'h02, 2), 1);
        send_unit(mk_fill(8'h09, 8'h00), 1, "R7");
        idle(2);
        // R7: stray bytes with no open unit are ignored (reference stays 9)
        stray_bytes(mk_fill(8'h09, 8'h00));
        idle(2);
        send_unit(mk_fill(8'h09, 8'h00), 0, "R7");
        settle("R7");

        // R8: overlong unit discarded, clears reference; exact limit passes
        send_unit(mk_unit(8'h09, 8'h3F, UNIT_MAX + 1), 0, "R8");
        idle(2);
        send_unit(mk_fill(8'h09, 8'h00), 1, "R8");
        send_unit(mk_unit(8'h0A, 8'h3F, UNIT_MAX), 1, "R8");
        settle("R8");

        // R9: back-to-back units, single-octet unit, order kept
        send_unit(mk_unit(8'h10, 8'h07, 10), 1, "R9");
        send_unit(mk_fill(8'h11, 8'h00), 1, "R9");
        send_unit(mk_unit(8'h55, 8'h00, 1), 1, "R9");
        send_unit(mk_fill(8'h12, 8'h00), 1, "R9");
        settle("R9");

        // R13: several maximum-length units with no gap
        for (int k = 0; k < 4; k++)
            send_unit(mk_unit(8'(k + 1), 8'h3F, UNIT_MAX), 1, "R13");
        send_unit(mk_fill(8'h20, 8'h00), 1, "R13");
        settle("R13");

        // R11: flush edge clears reference
        send_unit(mk_fill(8'h14, 8'h00), 1, "R11");
        settle("R11");
        @(posedge clk); #(Q);
        flush_ctl = 1'b1;
        idle(2);
        send_unit(mk_fill(8'h14, 8'h00), 1, "R11");
        settle("R11");
        // R11: holding high does not reset again
        send_unit(mk_fill(8'h14, 8'h00), 0, "R11");
        settle("R11");
        flush_ctl = 1'b0;
        // R11: flush during emission drops remaining bytes
        send_unit(mk_unit(8'h15, 8'h09, 40), 1, "R11");
        idle(4);
        @(posedge clk); #(Q);
        flush_ctl = 1'b1;
        @(posedge clk); #1;
        exp_q.delete();
        tag_q.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R11", "out_valid after flush edge", out_valid, 0);
        settle("R11");
        flush_ctl = 1'b0;
        idle(2);

        // R12: status delay and no effect on filtering
        @(posedge clk); #(Q);
        map_sel = 1'b1;
        @(negedge clk);
        check(map_sel_st == 1'b0, "R12", "status before edge", map_sel_st, 0);
        @(negedge clk);
        check(map_sel_st == 1'b1, "R12", "status after edge", map_sel_st, 1);
        send_unit(mk_fill(8'h30, 8'h00), 1, "R12");
        send_unit(mk_fill(8'h30, 8'h00), 0, "R12");
        settle("R12");

        report();
    end
endmodule